// File: doc/BRIEF.md
# Triggered Burst Window Capture

This block takes a free-running, four-lane sample stream and hands a bounded slice of it to an AXI4-Stream master port. Each lane carries one complex sample. Nothing is forwarded until software raises a one-cycle trigger. The block then waits for the next valid upstream beat and forwards a window of whole output frames. A frame is 128 beats, which is 512 samples. The number of frames per window comes from a register input. TLAST is set on the closing beat of every frame.

The trigger is not tied to upstream frame timing, so a window can begin in the middle of an upstream frame. While no window is open, the stream port shows zero valid, zero data and zero last. The sink may stall the port with TREADY. The upstream source cannot be paused, so beats that arrive during a stall are dropped. The window length is counted in accepted beats, not in clock cycles.

A busy flag marks an open window. A one-cycle done flag marks its end.

Top module: `burst_capture`

## Requirements
- R1: Reset rules:
  - While reset is high, and on the first cycle after it, `m_tvalid_o`, `m_tlast_o`, `m_tdata_o`, `busy_o` and `done_o` are all zero.
  - Reset is synchronous and active-high.
- R2: A `trig_i` pulse seen in idle with a non-zero `nframes_i` opens a window, and `busy_o` is high from the next cycle.
  - The first output beat is the first upstream beat with `up_valid_i` high that is sampled on the clock after the trigger.
  - This holds wherever that beat falls within an upstream frame.
- R3: A window transfers exactly `nframes_i` × 128 beats, then stops.
  - `nframes_i` is sampled at the trigger.
  - `nframes_i` is 11 bits, so any value from 1 to 2047 is valid, including 1024.
  - No counter wraps within a window.
- R4: `m_tlast_o` is high on the 128th, 256th, and every further 128th transferred beat of a window, and on no other beat.
- R5: Whenever `m_tvalid_o` is low, `m_tdata_o` is all zeros and `m_tlast_o` is low.
- R6: Lane and beat order:
  - A cycle with `up_valid_i` low yields no output beat.
  - Accepted beats leave in arrival order.
  - Lane k of a beat occupies bits [32k+31:32k] of both `up_data_i` and `m_tdata_o`.
- R7: Stall behaviour:
  - While `m_tvalid_o` is high and `m_tready_i` is low, the output beat, including its last flag, is held unchanged.
  - Upstream beats that arrive during the stall are discarded.
  - The window counters do not advance for discarded beats.
- R8: These triggers are ignored:
  - A `trig_i` pulse while `busy_o` is high. The window length is unchanged and only one done pulse occurs.
  - A `trig_i` pulse with `nframes_i` equal to 0. No window opens.
- R9: End of window:
  - In the cycle after the final beat is transferred, `done_o` is high for exactly one cycle and `busy_o` is low.
  - The block is idle on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Software capture trigger, one-cycle pulse |
| nframes_i | input | 11 | Frames per window, sampled at trigger |
| up_data_i | input | 128 | Upstream beat: four 32-bit complex samples |
| up_valid_i | input | 1 | Upstream beat valid |
| m_tdata_o | output | 128 | Stream data, zero outside a window |
| m_tvalid_o | output | 1 | Stream valid |
| m_tlast_o | output | 1 | End of 128-beat frame |
| m_tready_i | input | 1 | Stream ready from sink |
| busy_o | output | 1 | Window armed or capturing |
| done_o | output | 1 | One-cycle end-of-window pulse |

## Verification
The two functions that can land on the same clock are a sink stall and the frame-closing beat. A stall on that beat must keep TLAST held with the data and must not let the frame counter slip. To provoke this, the stall pattern drops TREADY one cycle in five. Because 5 does not divide 128, stalls fall on frame-end beats across the windows. Each held beat is compared with the previous cycle's output, and each TLAST position is checked against its transfer index. A second collision is a trigger arriving mid-window; it is judged by an unchanged beat count and a single done pulse.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_RUN   = 2'd2,
    CAP_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_beat_tracker.sv
module cap_beat_tracker #(
  parameter int BEATS = 128,
  parameter int NFR_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [NFR_W-1:0] nframes_i,
  output logic             frame_end_o,
  output logic             window_end_o
);
  localparam int BEAT_W = $clog2(BEATS);

  logic [BEAT_W-1:0] beat_q;
  logic [NFR_W-1:0]  frame_q;

  assign frame_end_o  = (beat_q == BEAT_W'(BEATS - 1));
  assign window_end_o = frame_end_o && (frame_q == (nframes_i - NFR_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      beat_q  <= '0;
      frame_q <= '0;
    end else if (step_i) begin
      if (frame_end_o) begin
        beat_q  <= '0;
        frame_q <= window_end_o ? '0 : frame_q + NFR_W'(1);
      end else begin
        beat_q <= beat_q + BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int NFR_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [NFR_W-1:0] nframes_i,
  input  logic             accept_i,
  input  logic             window_end_i,
  input  logic             out_xfer_i,
  output logic             start_o,
  output logic             open_o,
  output logic [NFR_W-1:0] nframes_q_o,
  output logic             busy_o,
  output logic             done_o
);
  cap_state_e       state_q;
  logic             taken_all_q;
  logic [NFR_W-1:0] nfr_q;

  assign start_o     = (state_q == CAP_IDLE) && trig_i && (nframes_i != '0);
  assign open_o      = ((state_q == CAP_ARMED) || (state_q == CAP_RUN)) && !taken_all_q;
  assign nframes_q_o = nfr_q;
  assign busy_o      = (state_q == CAP_ARMED) || (state_q == CAP_RUN);
  assign done_o      = (state_q == CAP_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= CAP_IDLE;
      taken_all_q <= 1'b0;
      nfr_q       <= '0;
    end else begin
      unique case (state_q)
        CAP_IDLE: begin
          taken_all_q <= 1'b0;
          if (start_o) begin
            nfr_q   <= nframes_i;
            state_q <= CAP_ARMED;
          end
        end
        CAP_ARMED: begin
          if (accept_i) begin
            state_q <= CAP_RUN;
            if (window_end_i) taken_all_q <= 1'b1;
          end
        end
        CAP_RUN: begin
          if (accept_i && window_end_i) taken_all_q <= 1'b1;
          if (taken_all_q && out_xfer_i) state_q <= CAP_DONE;
        end
        CAP_DONE: begin
          taken_all_q <= 1'b0;
          state_q     <= CAP_IDLE;
        end
        default: state_q <= CAP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cap_out_reg.sv
module cap_out_reg #(
  parameter int LANES = 4,
  parameter int SMP_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic                   take_i,
  input  logic                   last_i,
  input  logic [LANES*SMP_W-1:0] data_i,
  output logic [LANES*SMP_W-1:0] data_o,
  output logic                   valid_o,
  output logic                   last_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SMP_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (load_i) begin
        lane_q <= take_i ? data_i[k*SMP_W +: SMP_W] : '0;
      end
    end
    assign data_o[k*SMP_W +: SMP_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= take_i;
      last_o  <= take_i && last_i;
    end
  end
endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
  parameter int LANES         = 4,
  parameter int SMP_W         = 32,
  parameter int FRAME_SAMPLES = 512,
  parameter int NFR_W         = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   trig_i,
  input  logic [NFR_W-1:0]       nframes_i,
  input  logic [LANES*SMP_W-1:0] up_data_i,
  input  logic                   up_valid_i,
  output logic [LANES*SMP_W-1:0] m_tdata_o,
  output logic                   m_tvalid_o,
  output logic                   m_tlast_o,
  input  logic                   m_tready_i,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int BEATS = FRAME_SAMPLES / LANES;

  logic             start, open_win, accept, out_free, out_xfer;
  logic             frame_end, window_end;
  logic [NFR_W-1:0] nfr_q;
  logic             tvalid;

  assign out_free = !tvalid || m_tready_i;
  assign out_xfer = tvalid && m_tready_i;
  assign accept   = open_win && up_valid_i && out_free;

  cap_ctrl #(.NFR_W(NFR_W)) u_ctrl (
    .clk(clk), .rst(rst), .trig_i(trig_i), .nframes_i(nframes_i),
    .accept_i(accept), .window_end_i(window_end), .out_xfer_i(out_xfer),
    .start_o(start), .open_o(open_win), .nframes_q_o(nfr_q),
    .busy_o(busy_o), .done_o(done_o)
  );

  cap_beat_tracker #(.BEATS(BEATS), .NFR_W(NFR_W)) u_track (
    .clk(clk), .rst(rst), .clear_i(start), .step_i(accept),
    .nframes_i(nfr_q), .frame_end_o(frame_end), .window_end_o(window_end)
  );

  cap_out_reg #(.LANES(LANES), .SMP_W(SMP_W)) u_out (
    .clk(clk), .rst(rst), .load_i(out_free), .take_i(accept),
    .last_i(frame_end), .data_i(up_data_i),
    .data_o(m_tdata_o), .valid_o(tvalid), .last_o(m_tlast_o)
  );

  assign m_tvalid_o = tvalid;
endmodule

// File: rtl/burst_capture_chk.sv
module burst_capture_chk #(
  parameter int LANES         = 4,
  parameter int SMP_W         = 32,
  parameter int FRAME_SAMPLES = 512,
  parameter int NFR_W         = 11
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES*SMP_W-1:0] m_tdata_o,
  input logic                   m_tvalid_o,
  input logic                   m_tlast_o,
  input logic                   m_tready_i,
  input logic                   busy_o,
  input logic                   done_o
);
  localparam int BEATS  = FRAME_SAMPLES / LANES;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int WIN_W  = NFR_W + BEAT_W + 1;

  logic [WIN_W-1:0] win_cnt;

  always_ff @(posedge clk) begin
    if (rst || done_o) win_cnt <= '0;
    else if (m_tvalid_o && m_tready_i) win_cnt <= win_cnt + WIN_W'(1);
  end

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !m_tvalid_o |-> (m_tdata_o == '0) && !m_tlast_o);

  assert_valid_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    m_tvalid_o |-> busy_o);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid_o && !m_tready_i) |=> m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o));

  assert_last_pos_R4: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid_o && m_tlast_o) |-> (win_cnt[BEAT_W-1:0] == BEAT_W'(BEATS - 1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (win_cnt != '0) && (win_cnt[BEAT_W-1:0] == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o && !busy_o);
endmodule

bind burst_capture burst_capture_chk #(
  .LANES(LANES), .SMP_W(SMP_W), .FRAME_SAMPLES(FRAME_SAMPLES), .NFR_W(NFR_W)
) u_chk (
  .clk(clk), .rst(rst), .m_tdata_o(m_tdata_o), .m_tvalid_o(m_tvalid_o),
  .m_tlast_o(m_tlast_o), .m_tready_i(m_tready_i), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_burst_capture.sv
`timescale 1ns/1ps
module tb_burst_capture;
  localparam int LANES = 4;
  localparam int SMP_W = 32;
  localparam int NFR_W = 11;
  localparam int BEATS = 128;
  localparam int NVEC  = 6;
  // fields: [31:16] frames, [15:12] valid gaps, [11:8] ready stalls, [7:4] retrigger, [3:0] skew
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd1,    4'd0, 4'd0, 4'd0, 4'd3},
    {16'd3,    4'd1, 4'd0, 4'd0, 4'd7},
    {16'd2,    4'd0, 4'd1, 4'd0, 4'd1},
    {16'd4,    4'd1, 4'd1, 4'd0, 4'd5},
    {16'd2,    4'd0, 4'd0, 4'd1, 4'd2},
    {16'd1024, 4'd0, 4'd0, 4'd0, 4'd9}
  };

  logic clk = 1'b0;
  logic rst;
  logic trig_i;
  logic [NFR_W-1:0] nframes_i;
  logic [LANES*SMP_W-1:0] up_data_i;
  logic up_valid_i;
  logic [LANES*SMP_W-1:0] m_tdata_o;
  logic m_tvalid_o, m_tlast_o, m_tready_i, busy_o, done_o;

  always #2 clk = ~clk;

  burst_capture dut (
    .clk(clk), .rst(rst), .trig_i(trig_i), .nframes_i(nframes_i),
    .up_data_i(up_data_i), .up_valid_i(up_valid_i),
    .m_tdata_o(m_tdata_o), .m_tvalid_o(m_tvalid_o), .m_tlast_o(m_tlast_o),
    .m_tready_i(m_tready_i), .busy_o(busy_o), .done_o(done_o)
  );

  int n_checks = 0, n_fail = 0;
  int vmode = 0, rmode = 0, trig_req = 0;
  int cyc = 0;
  logic [15:0] stamp = 16'd0, exp_first = 16'd0;
  bit want_next = 0, want_first = 0;

  int mon_beats, mon_lasts, mon_pos_err, mon_zero_err, mon_first_err;
  int mon_seq_err, mon_lane_err, mon_hold_err, mon_done, mon_busy;
  bit have_prev, prev_stall, strict_seq, prev_last;
  logic [15:0] prev_stamp;
  logic [LANES*SMP_W-1:0] prev_data;

  task automatic check_eq(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic clear_mon();
    mon_beats = 0; mon_lasts = 0; mon_pos_err = 0; mon_zero_err = 0;
    mon_first_err = 0; mon_seq_err = 0; mon_lane_err = 0; mon_hold_err = 0;
    mon_done = 0; mon_busy = 0; have_prev = 0; prev_stall = 0;
  endtask

  // upstream source, trigger and sink ready
  initial begin
    trig_i = 0; up_valid_i = 0; up_data_i = '0; m_tready_i = 1; nframes_i = '0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (want_next) begin want_first = 1; want_next = 0; end
      if (trig_req != 0) begin
        trig_i = 1;
        if (trig_req == 1) want_next = 1;
        trig_req = 0;
      end else trig_i = 0;
      up_valid_i = (vmode == 0) || (cyc % 4 != 3);
      if (up_valid_i) begin
        for (int k = 0; k < LANES; k++) up_data_i[k*SMP_W +: SMP_W] = {stamp, 16'(k)};
        if (want_first) begin exp_first = stamp; want_first = 0; end
        stamp = stamp + 16'd1;
      end else begin
        up_data_i = {(LANES*SMP_W/16){16'hBEEF}};
      end
      m_tready_i = (rmode == 0) || (cyc % 5 != 2);
    end
  end

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o) mon_busy++;
      if (done_o) mon_done++;
      if (!m_tvalid_o && (m_tdata_o != '0 || m_tlast_o)) mon_zero_err++;   // R5
      if (prev_stall && !(m_tvalid_o && m_tdata_o == prev_data && m_tlast_o == prev_last))
        mon_hold_err++;                                                     // R7
      if (m_tvalid_o && m_tready_i) begin
        logic [15:0] s, d;
        s = m_tdata_o[31:16];
        for (int k = 0; k < LANES; k++)
          if (m_tdata_o[k*SMP_W +: SMP_W] != {s, 16'(k)}) mon_lane_err++;   // R6
        if (m_tlast_o != ((mon_beats % BEATS) == BEATS - 1)) mon_pos_err++; // R4
        if (m_tlast_o) mon_lasts++;
        if (!have_prev) begin
          if (s != exp_first) mon_first_err++;                              // R2
        end else begin
          d = s - prev_stamp;
          if (strict_seq ? (d != 16'd1) : (d == 16'd0 || d[15])) mon_seq_err++;
        end
        have_prev = 1; prev_stamp = s;
        mon_beats++;
      end
      prev_stall = m_tvalid_o && !m_tready_i;
      prev_data  = m_tdata_o;
      prev_last  = m_tlast_o;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary_and_end();
  end

  initial begin
    clear_mon();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check_eq("R1 tvalid in reset", int'(m_tvalid_o), 0);
    check_eq("R1 tdata in reset", int'(m_tdata_o != '0), 0);
    check_eq("R1 busy in reset", int'(busy_o), 0);
    @(posedge clk); rst = 0;
    @(negedge clk);
    check_eq("R1 tlast after reset", int'(m_tlast_o), 0);
    check_eq("R1 done after reset", int'(done_o), 0);

    // table-driven windows
    for (int v = 0; v < NVEC; v++) begin
      int nf, lim, got_done;
      nf = int'(VEC[v][31:16]);
      @(posedge clk);
      vmode = int'(VEC[v][15:12]); rmode = int'(VEC[v][11:8]);
      strict_seq = (rmode == 0);
      nframes_i = NFR_W'(nf);
      clear_mon();
      repeat (int'(VEC[v][3:0]) + 1) @(posedge clk);
      trig_req = 1;
      @(negedge clk);
      check_eq($sformatf("R2 busy before trigger seen v%0d", v), int'(busy_o), 0);
      @(negedge clk);
      check_eq($sformatf("R2 busy after trigger v%0d", v), int'(busy_o), 1);
      if (VEC[v][7:4] != 0) begin
        repeat (100) @(posedge clk);
        trig_req = 2;   // R8: mid-window trigger
      end
      lim = nf * BEATS * 3 + 500;
      got_done = 0;
      for (int c = 0; c < lim && got_done == 0; c++) begin
        @(negedge clk);
        if (done_o) got_done = 1;
      end
      @(negedge clk);
      check_eq($sformatf("R9 busy low after done v%0d", v), int'(busy_o), 0);
      repeat (4) @(negedge clk);
      check_eq($sformatf("R3 beats v%0d", v), mon_beats, nf * BEATS);
      check_eq($sformatf("R4 tlast count v%0d", v), mon_lasts, nf);
      check_eq($sformatf("R4 tlast position errors v%0d", v), mon_pos_err, 0);
      check_eq($sformatf("R5 idle nonzero v%0d", v), mon_zero_err, 0);
      check_eq($sformatf("R2 first beat v%0d", v), mon_first_err, 0);
      check_eq($sformatf("R6 order v%0d", v), mon_seq_err, 0);
      check_eq($sformatf("R6 lane placement v%0d", v), mon_lane_err, 0);
      check_eq($sformatf("R7 stall hold v%0d", v), mon_hold_err, 0);
      check_eq($sformatf("R9 done pulses v%0d", v), mon_done, 1);
      check_eq($sformatf("R8 idle after window v%0d", v), int'(m_tvalid_o || busy_o), 0);
    end

    // R8: zero frame count must not open a window
    @(posedge clk);
    vmode = 0; rmode = 0; nframes_i = '0;
    clear_mon();
    trig_req = 1;
    repeat (300) @(posedge clk);
    @(negedge clk);
    check_eq("R8 zero frames beats", mon_beats, 0);
    check_eq("R8 zero frames busy cycles", mon_busy, 0);
    check_eq("R8 zero frames done", mon_done, 0);

    // R1: reset in the middle of a window
    @(posedge clk);
    nframes_i = NFR_W'(2);
    trig_req = 1;
    repeat (40) @(posedge clk);
    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    check_eq("R1 tvalid after mid reset", int'(m_tvalid_o), 0);
    check_eq("R1 busy after mid reset", int'(busy_o), 0);
    summary_and_end();
  end
endmodule